// File: doc/BRIEF.md
# Tile Shape Configuration Unit

This unit holds the shape settings for a bank of eight matrix tile registers. Software-side logic streams a 64-byte configuration image into it, a few bytes per beat. Once the last beat arrives, the unit checks the image. It then either commits the image, returns to the init state, or rejects the image with a fault pulse. Downstream datapaths read the committed row count and bytes-per-row for each tile straight from its outputs. A separate storage block receives a one-cycle clear request whenever all tile data must read as zero.

The committed image can be streamed back out, one beat per cycle. A release command drops the unit back to the init state from any point. The controller is a four-state machine:
- IDLE: waits for a command.
- FILL: collects image beats. It moves to CHECK when the last beat arrives.
- CHECK: lasts one cycle. It commits, initialises or faults, then returns to IDLE.
- DUMP: streams every beat, then returns to IDLE.

Release moves every state to IDLE.

Top module: `tile_cfg_unit`

## Requirements
- R1: A load starts when `load_start_i` is seen in IDLE. The next 16 cycles with `wr_valid_i` high each carry 4 bytes. Lane k (bits 8k+7:8k) of beat n becomes image byte 4n+k. The image is judged on the cycle after the last beat, and the result is visible on the outputs the cycle after that.
- R2: Image byte 0 is the palette and byte 1 is the start row. Bytes 16+2t (low) and 17+2t (high) form the bytes-per-row of tile t, shown on `tile_bpr_o[16t+15:16t]`. Byte 48+t is the row count of tile t, shown on `tile_rows_o[8t+7:8t]`.
- R3: A palette-1 image is legal only if all of the following hold:
  - every tile has at most 16 rows;
  - every tile has at most 64 bytes per row;
  - the start row is below 16;
  - every byte outside the fields of R2 is zero.
- R4: A tile's row count and bytes-per-row must be zero together or nonzero together. Any other pairing makes the image illegal.
- R5: A palette above 1 makes the image illegal.
- R6: An illegal image raises `fault_o` for exactly one cycle. The previous configuration, including the configured flag, is kept.
- R7: A palette-0 image puts the unit in the init state, whatever the other bytes hold. It pulses `clear_o` for one cycle, clears `configured_o`, zeroes all fields and raises no fault.
- R8: `configured_o` rises only after a legal palette-1 load. Reset, release and palette-0 loads clear it.
- R9: `dump_start_i` seen in IDLE gives 16 consecutive cycles of `dump_valid_o`, starting on the next cycle. Beat n carries committed bytes 4n..4n+3 in the lane order of R1. While unconfigured, every beat is zero.
- R10: `release_i` in any state returns the unit to IDLE and aborts any load or dump. On the next cycle `clear_o` pulses and the unit is unconfigured with all fields zero.
- R11: In IDLE, release wins over load, and load wins over dump. A `wr_valid_i` outside FILL has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_start_i | input | 1 | Begin collecting an image |
| wr_valid_i | input | 1 | An image beat is present |
| wr_data_i | input | 32 | Image beat, lane 0 in the low byte |
| dump_start_i | input | 1 | Begin streaming the committed image |
| dump_valid_o | output | 1 | A readback beat is present |
| dump_data_o | output | 32 | Readback beat |
| release_i | input | 1 | Return to the init state |
| fault_o | output | 1 | One-cycle pulse for an illegal image |
| clear_o | output | 1 | One-cycle request to zero tile storage |
| configured_o | output | 1 | A legal nonzero palette is committed |
| tile_rows_o | output | 64 | Row count per tile |
| tile_bpr_o | output | 128 | Bytes-per-row per tile |

## Verification
The assertions check the following on every cycle:
- a fault is a lone pulse, and the committed image and flag stay unchanged across it;
- a clear never coincides with a configured unit;
- a release is always followed by a clear;
- readback beats are zero while unconfigured;
- the configured flag rises only out of CHECK;
- no configured tile exceeds the row limit.

Only the bench's scenarios can show the legality decision, the exact byte-to-field mapping, lane order, command priority and mid-load abort. For these, the bench drives legal, boundary and illegal images and compares every output each cycle against its behavioural model.

// File: rtl/tcfg_pkg.sv
package tcfg_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_CHECK, ST_DUMP} tcfg_state_e;

    localparam int PAL_OFS   = 0;
    localparam int START_OFS = 1;
    localparam int BPR_OFS   = 16;
    localparam int ROWS_OFS  = 48;

    // True when image byte idx belongs to a defined field
    function automatic bit is_field_byte(int idx, int ntiles);
        return (idx == PAL_OFS) || (idx == START_OFS)
            || (idx >= BPR_OFS  && idx < BPR_OFS + 2 * ntiles)
            || (idx >= ROWS_OFS && idx < ROWS_OFS + ntiles);
    endfunction
endpackage

// File: rtl/tcfg_stage.sv
module tcfg_stage #(
    parameter int IMG_BYTES = 64,
    parameter int BUS_BYTES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we_i,
    input  logic [$clog2(IMG_BYTES/BUS_BYTES)-1:0] beat_i,
    input  logic [BUS_BYTES*8-1:0]     data_i,
    output logic [IMG_BYTES*8-1:0]     img_o
);
    localparam int BEATS = IMG_BYTES / BUS_BYTES;
    localparam int BW    = $clog2(BEATS);
    localparam int BUS_W = BUS_BYTES * 8;

    for (genvar b = 0; b < BEATS; b++) begin : g_beat
        logic [BUS_W-1:0] hold_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          hold_q <= '0;
            else if (we_i && beat_i == BW'(b))   hold_q <= data_i;
        end
        assign img_o[b*BUS_W +: BUS_W] = hold_q;
    end
endmodule

// File: rtl/tcfg_check.sv
module tcfg_check #(
    parameter int IMG_BYTES = 64,
    parameter int NUM_TILES = 8,
    parameter int MAX_ROWS  = 16,
    parameter int MAX_BPR   = 64
) (
    input  logic [IMG_BYTES*8-1:0] img_i,
    output logic                   pal_zero_o,
    output logic                   img_ok_o
);
    import tcfg_pkg::*;

    localparam logic [7:0]  ROW_LIM = 8'(MAX_ROWS);
    localparam logic [15:0] BPR_LIM = 16'(MAX_BPR);

    logic [7:0]           palette;
    logic [7:0]           start_row;
    logic [NUM_TILES-1:0] tile_ok;
    logic [IMG_BYTES-1:0] rsv_bad;

    assign palette   = img_i[PAL_OFS*8 +: 8];
    assign start_row = img_i[START_OFS*8 +: 8];

    for (genvar t = 0; t < NUM_TILES; t++) begin : g_tile
        logic [7:0]  rows;
        logic [15:0] bpr;
        assign rows = img_i[(ROWS_OFS + t)*8 +: 8];
        assign bpr  = img_i[(BPR_OFS + 2*t)*8 +: 16];
        assign tile_ok[t] = (rows <= ROW_LIM) && (bpr <= BPR_LIM)
                          && ((rows == 8'd0) == (bpr == 16'd0));
    end

    for (genvar i = 0; i < IMG_BYTES; i++) begin : g_rsv
        localparam bit FIELD = is_field_byte(i, NUM_TILES);
        assign rsv_bad[i] = FIELD ? 1'b0 : (|img_i[i*8 +: 8]);
    end

    assign pal_zero_o = (palette == 8'd0);
    assign img_ok_o   = (palette == 8'd1) && (&tile_ok) && !(|rsv_bad)
                      && (start_row < ROW_LIM);
endmodule

// File: rtl/tile_cfg_unit.sv
module tile_cfg_unit #(
    parameter int NUM_TILES = 8,
    parameter int IMG_BYTES = 64,
    parameter int BUS_BYTES = 4,
    parameter int MAX_ROWS  = 16,
    parameter int MAX_BPR   = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_start_i,
    input  logic                      wr_valid_i,
    input  logic [BUS_BYTES*8-1:0]    wr_data_i,
    input  logic                      dump_start_i,
    output logic                      dump_valid_o,
    output logic [BUS_BYTES*8-1:0]    dump_data_o,
    input  logic                      release_i,
    output logic                      fault_o,
    output logic                      clear_o,
    output logic                      configured_o,
    output logic [NUM_TILES*8-1:0]    tile_rows_o,
    output logic [NUM_TILES*16-1:0]   tile_bpr_o
);
    import tcfg_pkg::*;

    localparam int BEATS = IMG_BYTES / BUS_BYTES;
    localparam int CNT_W = $clog2(BEATS);
    localparam int BUS_W = BUS_BYTES * 8;
    localparam int IMG_W = IMG_BYTES * 8;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

    tcfg_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [IMG_W-1:0] stage_img, cfg_img_q;
    logic             configured_q, fault_q, clear_q;
    logic             pal_zero, img_ok, stage_we;
    logic [BUS_W-1:0] beat_view [BEATS];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        if (release_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (load_start_i)      state_d = ST_FILL;
                          else if (dump_start_i) state_d = ST_DUMP;
                ST_FILL:  if (wr_valid_i && cnt_q == LAST) state_d = ST_CHECK;
                ST_CHECK: state_d = ST_IDLE;
                ST_DUMP:  if (cnt_q == LAST) state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // Beat counter shared by fill and dump
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (release_i || state_q == ST_IDLE)
            cnt_q <= '0;
        else if ((state_q == ST_FILL && wr_valid_i) || state_q == ST_DUMP)
            cnt_q <= cnt_q + 1'b1;
    end

    assign stage_we = (state_q == ST_FILL) && wr_valid_i && !release_i;

    tcfg_stage #(.IMG_BYTES(IMG_BYTES), .BUS_BYTES(BUS_BYTES)) stage_i (
        .clk(clk), .rst_n(rst_n), .we_i(stage_we), .beat_i(cnt_q),
        .data_i(wr_data_i), .img_o(stage_img)
    );

    tcfg_check #(.IMG_BYTES(IMG_BYTES), .NUM_TILES(NUM_TILES),
                 .MAX_ROWS(MAX_ROWS), .MAX_BPR(MAX_BPR)) check_i (
        .img_i(stage_img), .pal_zero_o(pal_zero), .img_ok_o(img_ok)
    );

    // Commit, init and fault decisions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_img_q    <= '0;
            configured_q <= 1'b0;
            fault_q      <= 1'b0;
            clear_q      <= 1'b0;
        end else begin
            fault_q <= 1'b0;
            clear_q <= 1'b0;
            if (release_i) begin
                cfg_img_q    <= '0;
                configured_q <= 1'b0;
                clear_q      <= 1'b1;
            end else if (state_q == ST_CHECK) begin
                if (pal_zero) begin
                    cfg_img_q    <= '0;
                    configured_q <= 1'b0;
                    clear_q      <= 1'b1;
                end else if (img_ok) begin
                    cfg_img_q    <= stage_img;
                    configured_q <= 1'b1;
                end else begin
                    fault_q <= 1'b1;
                end
            end
        end
    end

    for (genvar b = 0; b < BEATS; b++) begin : g_view
        assign beat_view[b] = cfg_img_q[b*BUS_W +: BUS_W];
    end

    for (genvar t = 0; t < NUM_TILES; t++) begin : g_out
        assign tile_rows_o[t*8 +: 8]  = cfg_img_q[(ROWS_OFS + t)*8 +: 8];
        assign tile_bpr_o[t*16 +: 16] = cfg_img_q[(BPR_OFS + 2*t)*8 +: 16];

        // R3
        rows_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            configured_o |-> tile_rows_o[t*8 +: 8] <= 8'(MAX_ROWS));
    end

    // Outputs
    always_comb begin
        dump_valid_o = (state_q == ST_DUMP);
        dump_data_o  = dump_valid_o ? beat_view[cnt_q] : '0;
        fault_o      = fault_q;
        clear_o      = clear_q;
        configured_o = configured_q;
    end

    // R6
    fault_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> !fault_o);
    // R6
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> $stable(cfg_img_q) && $stable(configured_o));
    // R7
    clear_unconf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_o |-> !configured_o && !fault_o);
    // R9
    dump_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dump_valid_o && !configured_o) |-> dump_data_o == '0);
    // R10
    release_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |=> clear_o && !configured_o);
    // R8
    cfg_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(configured_o) |-> $past(state_q) == ST_CHECK);
endmodule

// File: tb/tile_cfg_unit_tb_top.sv
`timescale 1ns/1ps
module tile_cfg_unit_tb_top;
    localparam int NT = 8, IB = 64, BB = 4, BEATS = 16;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, load_start, wr_valid, dump_start, rel;
    logic [31:0] wr_data;
    logic dump_valid, fault, clear, configured;
    logic [31:0] dump_data;
    logic [NT*8-1:0]  rows_o;
    logic [NT*16-1:0] bpr_o;

    tile_cfg_unit dut_i (
        .clk(clk), .rst_n(rst_n), .load_start_i(load_start), .wr_valid_i(wr_valid),
        .wr_data_i(wr_data), .dump_start_i(dump_start), .dump_valid_o(dump_valid),
        .dump_data_o(dump_data), .release_i(rel), .fault_o(fault), .clear_o(clear),
        .configured_o(configured), .tile_rows_o(rows_o), .tile_bpr_o(bpr_o)
    );

    int checks = 0, fails = 0, fault_cnt = 0, clear_cnt = 0;
    bit done = 0;
    byte unsigned m_img[IB], m_stage[IB], buf_img[IB];
    int m_mode = 0, m_cnt = 0;   // 0 idle, 1 fill, 2 judge, 3 readback
    bit m_cfg = 0, m_fault = 0, m_clear = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit ref_legal();
        if (m_stage[0] != 1) return 0;
        if (m_stage[1] >= 16) return 0;
        for (int i = 2; i < IB; i++) begin
            bit used = (i >= 16 && i < 16 + 2*NT) || (i >= 48 && i < 48 + NT);
            if (!used && m_stage[i] != 0) return 0;
        end
        for (int t = 0; t < NT; t++) begin
            int r = m_stage[48+t];
            int w = m_stage[16+2*t] + 256 * m_stage[17+2*t];
            if (r > 16 || w > 64) return 0;
            if ((r == 0) != (w == 0)) return 0;
        end
        return 1;
    endfunction

    // Behavioural reference model
    always @(posedge clk) begin
        m_fault = 0; m_clear = 0;
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_cfg = 0;
            foreach (m_img[i]) m_img[i] = 0;
        end else if (rel) begin
            m_mode = 0; m_cnt = 0; m_cfg = 0; m_clear = 1;
            foreach (m_img[i]) m_img[i] = 0;
        end else begin
            case (m_mode)
                0: begin
                    m_cnt = 0;
                    if (load_start) m_mode = 1;
                    else if (dump_start) m_mode = 3;
                end
                1: if (wr_valid) begin
                    for (int k = 0; k < BB; k++) m_stage[m_cnt*BB+k] = wr_data[8*k +: 8];
                    if (m_cnt == BEATS-1) m_mode = 2;
                    m_cnt++;
                end
                2: begin
                    m_mode = 0;
                    if (m_stage[0] == 0) begin
                        m_cfg = 0; m_clear = 1;
                        foreach (m_img[i]) m_img[i] = 0;
                    end else if (ref_legal()) begin
                        m_cfg = 1;
                        foreach (m_img[i]) m_img[i] = m_stage[i];
                    end else m_fault = 1;
                end
                default: begin
                    m_cnt++;
                    if (m_cnt == BEATS) m_mode = 0;
                end
            endcase
        end
    end

    // Per-cycle comparison
    always @(negedge clk) if (rst_n && !done) begin
        logic [31:0] exp_d;
        exp_d = 0;
        if (m_mode == 3)
            for (int k = 0; k < BB; k++) exp_d[8*k +: 8] = m_img[m_cnt*BB+k];
        if (fault) fault_cnt++;
        if (clear) clear_cnt++;
        chk(fault == m_fault, "R6", "fault_o", fault, m_fault);
        chk(clear == m_clear, "R7", "clear_o", clear, m_clear);
        chk(configured == m_cfg, "R8", "configured_o", configured, m_cfg);
        chk(dump_valid == (m_mode == 3), "R9", "dump_valid_o", dump_valid, m_mode == 3);
        chk(dump_data == exp_d, "R9", "dump_data_o", dump_data, exp_d);
        for (int t = 0; t < NT; t++) begin
            chk(rows_o[8*t +: 8] == m_img[48+t], "R2", "tile rows", rows_o[8*t +: 8], m_img[48+t]);
            chk(bpr_o[16*t +: 16] == {m_img[17+2*t], m_img[16+2*t]}, "R2", "tile bpr",
                bpr_o[16*t +: 16], {m_img[17+2*t], m_img[16+2*t]});
        end
    end

    task automatic tick();
        @(negedge clk); #0.5;
    endtask

    task automatic clr_buf();
        foreach (buf_img[i]) buf_img[i] = 0;
    endtask

    task automatic set_tile(input int t, input int r, input int w);
        buf_img[48+t] = 8'(r);
        buf_img[16+2*t] = 8'(w);
        buf_img[17+2*t] = 8'(w >> 8);
    endtask

    task automatic send_beats(input int from, input int upto);
        for (int n = from; n < upto; n++) begin
            wr_valid = 1;
            for (int k = 0; k < BB; k++) wr_data[8*k +: 8] = buf_img[n*BB+k];
            tick();
        end
        wr_valid = 0;
    endtask

    task automatic load_img();
        load_start = 1; tick(); load_start = 0;
        send_beats(0, BEATS);
        tick(); tick();
    endtask

    task automatic dump_img();
        dump_start = 1; tick(); dump_start = 0;
        repeat (BEATS + 1) tick();
    endtask

    task automatic report();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5.0);
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        int f0;
        rst_n = 0; load_start = 0; wr_valid = 0; dump_start = 0; rel = 0; wr_data = 0;
        repeat (3) tick();
        // R8 reset state
        chk(configured == 0 && fault == 0 && clear == 0 && rows_o == 0, "R8", "reset state",
            {configured, fault, clear}, 0);
        rst_n = 1; tick();

        // R9 readback while unconfigured
        dump_img();

        // R1 R2 legal image at the limits
        clr_buf(); buf_img[0] = 1; buf_img[1] = 15;
        set_tile(0, 16, 64); set_tile(1, 3, 12); set_tile(7, 1, 1);
        load_img();
        chk(configured == 1, "R1", "legal load configured", configured, 1);
        chk(rows_o[7:0] == 16 && bpr_o[15:0] == 64, "R2", "tile0 shape", rows_o[7:0], 16);
        dump_img();

        // R3 rows over limit
        f0 = fault_cnt;
        clr_buf(); buf_img[0] = 1; set_tile(2, 17, 8); load_img();
        chk(fault_cnt == f0 + 1, "R3", "row limit fault count", fault_cnt - f0, 1);
        chk(configured == 1 && rows_o[15:8] == 3, "R6", "config kept", rows_o[15:8], 3);
        // R3 bpr over limit
        clr_buf(); buf_img[0] = 1; set_tile(2, 4, 65); load_img();
        chk(fault_cnt == f0 + 2, "R3", "bpr limit fault count", fault_cnt - f0, 2);
        // R3 reserved byte and start row
        clr_buf(); buf_img[0] = 1; buf_img[40] = 8'h5A; load_img();
        clr_buf(); buf_img[0] = 1; buf_img[1] = 16; load_img();
        chk(fault_cnt == f0 + 4, "R3", "reserved/start faults", fault_cnt - f0, 4);
        // R4 mismatched zero fields
        clr_buf(); buf_img[0] = 1; set_tile(5, 0, 4); load_img();
        clr_buf(); buf_img[0] = 1; set_tile(5, 2, 0); load_img();
        chk(fault_cnt == f0 + 6, "R4", "pairing faults", fault_cnt - f0, 6);
        // R5 palette 2
        clr_buf(); buf_img[0] = 2; set_tile(0, 1, 1); load_img();
        chk(fault_cnt == f0 + 7, "R5", "palette fault", fault_cnt - f0, 7);
        chk(configured == 1, "R6", "still configured", configured, 1);

        // R7 palette zero with junk bytes
        f0 = clear_cnt;
        clr_buf(); buf_img[40] = 8'hFF; set_tile(3, 99, 999); load_img();
        chk(clear_cnt == f0 + 1 && configured == 0 && rows_o == 0, "R7", "init load",
            clear_cnt - f0, 1);
        dump_img();

        // R11 load wins over dump, wr_valid outside a load ignored
        wr_valid = 1; wr_data = 32'hFFFF_FFFF; tick(); tick(); wr_valid = 0;
        clr_buf(); buf_img[0] = 1; set_tile(4, 8, 32);
        load_start = 1; dump_start = 1; tick(); load_start = 0; dump_start = 0;
        send_beats(0, BEATS); tick(); tick();
        chk(configured == 1 && rows_o[39:32] == 8, "R11", "load priority", rows_o[39:32], 8);

        // R10 release mid-dump, then mid-load
        dump_start = 1; tick(); dump_start = 0; tick(); tick();
        rel = 1; tick(); rel = 0;
        chk(configured == 0 && clear == 1, "R10", "release during dump", configured, 0);
        clr_buf(); buf_img[0] = 1; set_tile(0, 2, 2);
        load_start = 1; tick(); load_start = 0;
        send_beats(0, 5);
        rel = 1; load_start = 1; tick(); rel = 0; load_start = 0;
        send_beats(5, BEATS); tick(); tick();
        chk(configured == 0 && rows_o == 0, "R10", "aborted load", configured, 0);
        dump_img();

        tick();
        report();
    end
endmodule